// File: doc/BRIEF.md
# Reset-Aware External Bus Master with Refresh and Bus Release

This block drives the external memory bus for an internal requester. It runs single accesses of byte, word or longword size, and 16-byte bursts made of four longword units. It also issues memory refresh cycles, which come from an interval counter it keeps itself. It hands the whole bus to another master whenever that master raises a release request.

The block reacts to two kinds of reset in different ways. A power-on reset clears everything asynchronously, deasserts every strobe and turns the output drivers off in the same instant. A manual reset is gentle. It keeps the refresh interval setting and lets the current longword unit finish, and a burst is cut at that unit. It stops the refresh counter and starts no refresh, and it still answers release requests.

The external bus is described by strobes. `busCs` marks an access unit and `busRef` marks a refresh cycle. `busOe` is the output-enable of all bus drivers: when it is low, the bus is tri-stated.

Top module: `xbus_arbiter`

## Requirements
- R1: While `porRstN` is low, `busOe`, `busCs`, `busRef`, `relGnt` and `reqDone` are 0 at once, with no clock edge needed. After it is released, the refresh interval is back at `REF_DEFAULT`.
- R2: A single access lasts `CYC_LEN` clocks with `busCs` high. During that time `busAddr` holds the request address and `busSize` holds the request size code (0 byte, 1 word, 2 longword). It is followed by a one-clock `reqDone` with `reqAborted` low.
- R3: A burst runs four longword units of `CYC_LEN` clocks each, with `busSize` equal to 2. The first unit uses the request address with its low four bits cleared, and each following unit adds 4.
- R4: The refresh counter advances once per clock. When it equals the interval setting it raises a refresh request and restarts from zero, so refresh cycles begin every interval+1 clocks. Each refresh cycle holds `busRef` high for `CYC_LEN` clocks.
- R5: A pending refresh is served before a new access. A continuous stream of access requests never delays refresh cycles beyond their period, and `busCs` and `busRef` are never high together.
- R6: While `manRst` is high, no new access is accepted and `reqReady` is 0. An access unit already running completes normally. The interval setting survives a manual reset.
- R7: When a burst unit ends while `manRst` is high, the burst stops there. `reqDone` and `reqAborted` pulse together.
- R8: While `manRst` is high, the refresh counter holds its value and no refresh cycle starts. A refresh spacing that spans M manual-reset clocks grows by exactly M.
- R9: A release request is granted only between bus cycles: a burst in progress runs to its end first. While released, `relGnt` is 1 and `busOe` is 0, and the release holds as long as `relReq` stays high.
- R10: After `relReq` falls, `relGnt` drops on the next clock. `busOe` stays 0 for that one idle clock and returns to 1 on the clock after.
- R11: A rising `manRst` while the bus is released drops `relGnt`, but the bus stays released. A release requested while `manRst` is already high is granted with `relGnt` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| manRst | input | 1 | Manual reset, synchronous, active high |
| reqValid | input | 1 | Internal access request |
| reqAddr | input | AW | Request byte address |
| reqSize | input | 2 | Size code: 0 byte, 1 word, 2 longword |
| reqBurst | input | 1 | Request is a 16-byte burst |
| reqReady | output | 1 | Request is accepted at this clock edge if valid |
| reqDone | output | 1 | One-clock completion pulse |
| reqAborted | output | 1 | With reqDone: burst was cut short |
| refWrEn | input | 1 | Write strobe for the refresh interval setting |
| refWrData | input | RW | New refresh interval |
| relReq | input | 1 | Release request from another master |
| relGnt | output | 1 | Release grant acknowledge |
| busOe | output | 1 | Bus output drivers enabled (0 = tri-stated) |
| busCs | output | 1 | Access unit strobe |
| busRef | output | 1 | Refresh cycle strobe |
| busAddr | output | AW | Bus address during busCs |
| busSize | output | 2 | Bus size code during busCs |

## Verification
The bench drives a manual reset into the second unit of a burst. A design that ignored it would run all eight strobe clocks and report no abort. A design that acted on it too early would leave the unit short of `CYC_LEN` clocks. The bench also holds a manual reset across a refresh period and measures the stretched spacing. A counter that kept running, or one that cleared on manual reset, would give the wrong gap, and a design that lost the interval setting would give a gap near the default.

Release is checked in three cases: raised in the middle of a burst, dropped, and hit by a manual reset. These catch a grant that cuts a cycle short, a reclaim with no idle clock, and a grant that stays high or a bus that comes back during a manual reset. A power-on reset in the middle of an access must silence the strobes before any clock edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_XFER, ST_REFR, ST_REL, ST_RECL
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic stepCyc;
    logic nextBeat;
    logic refTake;
  } dpCtl_t;
endpackage

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 12,
  parameter int CYC_LEN = 2,
  parameter int REF_DEFAULT = 100
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          manRst,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic          reqBurst,
  input  logic          refWrEn,
  input  logic [RW-1:0] refWrData,
  output logic [AW-1:0] curAddr,
  output logic [1:0]    curSize,
  output logic          curBurst,
  output logic          unitEnd,
  output logic          lastBeat,
  output logic          refPend
);
  localparam int CW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_LEN - 1);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(15);
  localparam logic [AW-1:0] UNIT_STEP = AW'(4);

  logic [CW-1:0] cyc;
  logic [1:0]    beat;
  logic [RW-1:0] interval;
  logic [RW-1:0] refCnt;

  assign unitEnd  = (cyc == CYC_LAST);
  assign lastBeat = (beat == 2'd3);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cyc      <= '0;
      beat     <= '0;
      curAddr  <= '0;
      curSize  <= '0;
      curBurst <= 1'b0;
    end else begin
      if (ctl.loadReq || ctl.refTake) cyc <= '0;
      else if (ctl.stepCyc) cyc <= unitEnd ? '0 : cyc + 1'b1;

      if (ctl.loadReq) begin
        beat     <= '0;
        curBurst <= reqBurst;
        curSize  <= reqBurst ? 2'd2 : reqSize;
        curAddr  <= reqBurst ? (reqAddr & ALIGN_MASK) : reqAddr;
      end else if (ctl.nextBeat) begin
        beat    <= beat + 1'b1;
        curAddr <= curAddr + UNIT_STEP;
      end
    end
  end

  // refresh interval setting and counter; frozen while manRst is high
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      interval <= RW'(REF_DEFAULT);
      refCnt   <= '0;
      refPend  <= 1'b0;
    end else begin
      if (refWrEn) interval <= refWrData;
      if (ctl.refTake) refPend <= 1'b0;
      if (!manRst) begin
        if (refCnt == interval) begin
          refCnt  <= '0;
          refPend <= 1'b1;
        end else begin
          refCnt <= refCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   porRstN,
  input  logic   manRst,
  input  logic   reqValid,
  input  logic   relReq,
  input  logic   unitEnd,
  input  logic   lastBeat,
  input  logic   refPend,
  input  logic   curBurst,
  output dpCtl_t ctl,
  output logic   reqReady,
  output logic   reqDone,
  output logic   reqAborted,
  output logic   relGnt,
  output logic   busOe,
  output logic   busCs,
  output logic   busRef
);
  busState_t state, nxt;
  logic doneSet, abortSet;
  logic manRstQ, gntDrop;

  always_comb begin
    nxt      = state;
    ctl      = '0;
    doneSet  = 1'b0;
    abortSet = 1'b0;
    case (state)
      ST_IDLE: begin
        if (relReq) nxt = ST_REL;
        else if (refPend && !manRst) begin
          nxt = ST_REFR;
          ctl.refTake = 1'b1;
        end else if (reqValid && !manRst) begin
          nxt = ST_XFER;
          ctl.loadReq = 1'b1;
        end
      end
      ST_XFER: begin
        ctl.stepCyc = 1'b1;
        if (unitEnd) begin
          if (curBurst && !lastBeat && !manRst) ctl.nextBeat = 1'b1;
          else begin
            nxt      = ST_IDLE;
            doneSet  = 1'b1;
            abortSet = curBurst && !lastBeat;
          end
        end
      end
      ST_REFR: begin
        ctl.stepCyc = 1'b1;
        if (unitEnd) nxt = ST_IDLE;
      end
      ST_REL:  if (!relReq) nxt = ST_RECL;
      ST_RECL: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state      <= ST_IDLE;
      reqDone    <= 1'b0;
      reqAborted <= 1'b0;
      manRstQ    <= 1'b0;
      gntDrop    <= 1'b0;
    end else begin
      state      <= nxt;
      reqDone    <= doneSet;
      reqAborted <= abortSet;
      manRstQ    <= manRst;
      if (state != ST_REL) gntDrop <= 1'b0;
      else if (manRst && !manRstQ) gntDrop <= 1'b1;
    end
  end

  assign reqReady = porRstN && (state == ST_IDLE) && !relReq && !refPend && !manRst;
  assign busOe    = porRstN && (state != ST_REL) && (state != ST_RECL);
  assign busCs    = porRstN && (state == ST_XFER);
  assign busRef   = porRstN && (state == ST_REFR);
  assign relGnt   = porRstN && (state == ST_REL) && !gntDrop;
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 12,
  parameter int CYC_LEN = 2,
  parameter int REF_DEFAULT = 100
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          manRst,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic          reqBurst,
  output logic          reqReady,
  output logic          reqDone,
  output logic          reqAborted,
  input  logic          refWrEn,
  input  logic [RW-1:0] refWrData,
  input  logic          relReq,
  output logic          relGnt,
  output logic          busOe,
  output logic          busCs,
  output logic          busRef,
  output logic [AW-1:0] busAddr,
  output logic [1:0]    busSize
);
  dpCtl_t        ctl;
  logic [AW-1:0] curAddr;
  logic [1:0]    curSize;
  logic          curBurst, unitEnd, lastBeat, refPend;

  xbus_datapath #(.AW(AW), .RW(RW), .CYC_LEN(CYC_LEN), .REF_DEFAULT(REF_DEFAULT)) u_dp (
    .clk(clk), .porRstN(porRstN), .manRst(manRst), .ctl(ctl),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqBurst(reqBurst),
    .refWrEn(refWrEn), .refWrData(refWrData),
    .curAddr(curAddr), .curSize(curSize), .curBurst(curBurst),
    .unitEnd(unitEnd), .lastBeat(lastBeat), .refPend(refPend)
  );

  xbus_ctrl u_ctrl (
    .clk(clk), .porRstN(porRstN), .manRst(manRst), .reqValid(reqValid),
    .relReq(relReq), .unitEnd(unitEnd), .lastBeat(lastBeat),
    .refPend(refPend), .curBurst(curBurst), .ctl(ctl),
    .reqReady(reqReady), .reqDone(reqDone), .reqAborted(reqAborted),
    .relGnt(relGnt), .busOe(busOe), .busCs(busCs), .busRef(busRef)
  );

  assign busAddr = busCs ? curAddr : '0;
  assign busSize = busCs ? curSize : '0;
endmodule

// File: rtl/xbus_arbiter_chk.sv
module xbus_arbiter_chk (
  input logic clk,
  input logic porRstN,
  input logic manRst,
  input logic busCs,
  input logic busRef,
  input logic busOe,
  input logic relGnt,
  input logic reqDone,
  input logic reqAborted
);
  always @(negedge clk) begin
    if (!porRstN) begin
      a_r1_por_quiet: assert (!busOe && !busCs && !busRef && !relGnt && !reqDone);
    end
  end

  a_r5_cs_ref_exclusive: assert property (@(posedge clk) disable iff (!porRstN)
    !(busCs && busRef));

  a_r2_done_follows_cycle: assert property (@(posedge clk) disable iff (!porRstN)
    reqDone |-> $past(busCs));

  a_r7_abort_with_done: assert property (@(posedge clk) disable iff (!porRstN)
    reqAborted |-> reqDone);

  a_r8_no_refresh_start: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(busRef) |-> !$past(manRst));

  a_r9_gnt_tristate: assert property (@(posedge clk) disable iff (!porRstN)
    relGnt |-> !busOe);

  a_r9_grant_at_boundary: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(relGnt) |-> (!$past(busCs) && !$past(busRef)));

  a_r10_idle_after_release: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(relGnt) && !manRst |-> !busOe);
endmodule

bind xbus_arbiter xbus_arbiter_chk u_chk (
  .clk(clk), .porRstN(porRstN), .manRst(manRst), .busCs(busCs),
  .busRef(busRef), .busOe(busOe), .relGnt(relGnt), .reqDone(reqDone),
  .reqAborted(reqAborted)
);

// File: tb/xbus_arbiter_bench.sv
module xbus_arbiter_bench;
  localparam int AW = 16;
  localparam int RW = 12;
  localparam int CYC = 2;
  localparam int REF_DEF = 100;

  logic clk = 1'b0;
  logic porRstN = 1'b0, manRst = 1'b0, reqValid = 1'b0, reqBurst = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic refWrEn = 1'b0;
  logic [RW-1:0] refWrData = '0;
  logic relReq = 1'b0;
  logic reqReady, reqDone, reqAborted, relGnt, busOe, busCs, busRef;
  logic [AW-1:0] busAddr;
  logic [1:0] busSize;

  int checks = 0, errors = 0;
  int tickN = 0, lastRise = 0, prevRise = 0, refRises = 0;
  logic refQ = 1'b0;

  always #10 clk = ~clk;

  xbus_arbiter #(.AW(AW), .RW(RW), .CYC_LEN(CYC), .REF_DEFAULT(REF_DEF)) u_xbus_arbiter (
    .clk(clk), .porRstN(porRstN), .manRst(manRst), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqBurst(reqBurst),
    .reqReady(reqReady), .reqDone(reqDone), .reqAborted(reqAborted),
    .refWrEn(refWrEn), .refWrData(refWrData), .relReq(relReq),
    .relGnt(relGnt), .busOe(busOe), .busCs(busCs), .busRef(busRef),
    .busAddr(busAddr), .busSize(busSize)
  );

  // refresh monitor
  always @(negedge clk) begin
    tickN++;
    if (busRef && !refQ) begin
      prevRise = lastRise;
      lastRise = tickN;
      refRises++;
    end
    refQ = busRef;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic setInterval(input int v);
    refWrData = RW'(v);
    refWrEn = 1'b1;
    tick();
    refWrEn = 1'b0;
  endtask

  // runs one request; cutAt/relAt = busCs cycle count after which manRst/relReq rise (-1 none)
  task automatic runAccess(input logic [AW-1:0] a, input logic [1:0] sz, input logic burst,
                           input int cutAt, input int relAt,
                           output int cs, output int ab, output int addrErr, output int sizeErr);
    logic rdy;
    logic [AW-1:0] expA;
    int guard;
    cs = 0; ab = -1; addrErr = 0; sizeErr = 0; guard = 0;
    reqAddr = a; reqSize = sz; reqBurst = burst; reqValid = 1'b1;
    do begin
      rdy = reqReady;
      tick();
      guard++;
    end while (!rdy && guard < 400);
    reqValid = 1'b0;
    while (guard < 400) begin
      if (busCs) begin
        expA = burst ? ((a & 16'hFFF0) + AW'(4 * (cs / CYC))) : a;
        if (busAddr !== expA) addrErr++;
        if (busSize !== (burst ? 2'd2 : sz)) sizeErr++;
        cs++;
        if (cs == cutAt) manRst = 1'b1;
        if (cs == relAt) relReq = 1'b1;
      end
      if (reqDone) begin
        ab = reqAborted;
        break;
      end
      tick();
      guard++;
    end
  endtask

  task automatic waitRises(input int n);
    int base = refRises;
    int guard = 0;
    while (refRises < base + n && guard < 2000) begin
      tick();
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cs, ab, ae, se, base, dn, hi;
    tick();
    chk("R1 busOe in reset", busOe, 0);
    chk("R1 busCs in reset", busCs, 0);
    chk("R1 relGnt in reset", relGnt, 0);
    porRstN = 1'b1;
    tick();
    chk("R1 busOe after reset", busOe, 1);
    chk("R1 reqReady after reset", reqReady, 1);
    // R1/R4: default interval spacing
    waitRises(2);
    chk("R1 default refresh gap", lastRise - prevRise, REF_DEF + 1);

    // R4: programmed spacing and strobe width
    setInterval(10);
    waitRises(3);
    chk("R4 refresh gap", lastRise - prevRise, 11);
    hi = 0;
    for (int i = 0; i < 8; i++) begin
      if (busRef) hi++;
      tick();
    end
    chk("R4 busRef width within window", hi >= CYC && hi <= 2 * CYC, 1);

    // R8 and R6 (interval kept): freeze spans 25 clocks
    waitRises(1);
    manRst = 1'b1;
    base = refRises;
    repeat (25) tick();
    chk("R8 no refresh during manual reset", refRises, base);
    manRst = 1'b0;
    waitRises(1);
    chk("R8 stretched gap / R6 interval kept", lastRise - prevRise, 11 + 25);

    // R5: refresh keeps its pace under a request stream
    base = refRises; dn = 0;
    reqAddr = 16'h0100; reqSize = 2'd2; reqBurst = 1'b0; reqValid = 1'b1;
    for (int i = 0; i < 44; i++) begin
      tick();
      if (reqDone) dn++;
    end
    reqValid = 1'b0;
    chk("R5 refreshes served under load", (refRises - base) >= 3, 1);
    chk("R5 accesses still served", dn >= 8, 1);

    setInterval(2000);
    repeat (4) tick();

    // R2: single access sweep
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < 6; i++) begin
        runAccess(AW'(i * 16'h1357 + s), 2'(s), 1'b0, -1, -1, cs, ab, ae, se);
        chk("R2 single cs length", cs, CYC);
        chk("R2 single address", ae, 0);
        chk("R2 single size", se, 0);
        chk("R2 single not aborted", ab, 0);
      end
    end
    // R3: burst sweep
    for (int i = 0; i < 8; i++) begin
      runAccess(AW'(i * 16'h0A4B + 16'h0023), 2'd0, 1'b1, -1, -1, cs, ab, ae, se);
      chk("R3 burst cs length", cs, 4 * CYC);
      chk("R3 burst addresses", ae, 0);
      chk("R3 burst size", se, 0);
      chk("R3 burst not aborted", ab, 0);
    end

    // R7: manual reset in the second unit
    runAccess(16'h4448, 2'd0, 1'b1, CYC + 1, -1, cs, ab, ae, se);
    chk("R7 cut burst cs length", cs, 2 * CYC);
    chk("R7 cut burst aborted", ab, 1);
    chk("R7 cut burst addresses", ae, 0);
    // R6: no acceptance while manual reset held
    hi = 0;
    reqValid = 1'b1; reqBurst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busCs || reqReady) hi++;
      tick();
    end
    reqValid = 1'b0;
    manRst = 1'b0;
    chk("R6 nothing accepted in manual reset", hi, 0);
    // R6: single unit completes under manual reset
    runAccess(16'h0042, 2'd1, 1'b0, 1, -1, cs, ab, ae, se);
    manRst = 1'b0;
    chk("R6 single completes under manual reset", cs, CYC);
    chk("R6 single not aborted", ab, 0);

    // R9/R10: release requested mid-burst
    runAccess(16'h8000, 2'd0, 1'b1, -1, 3, cs, ab, ae, se);
    chk("R9 burst finishes before grant", cs, 4 * CYC);
    tick();
    chk("R9 grant", relGnt, 1);
    chk("R9 tri-stated", busOe, 0);
    repeat (5) tick();
    chk("R9 release held", relGnt, 1);
    relReq = 1'b0;
    tick();
    chk("R10 grant dropped", relGnt, 0);
    chk("R10 idle clock still tri-stated", busOe, 0);
    tick();
    chk("R10 bus reclaimed", busOe, 1);

    // R11: manual reset while released
    relReq = 1'b1;
    tick();
    chk("R11 granted", relGnt, 1);
    manRst = 1'b1;
    tick();
    chk("R11 grant dropped on manual reset", relGnt, 0);
    repeat (3) tick();
    chk("R11 still released", busOe, 0);
    relReq = 1'b0;
    repeat (2) tick();
    chk("R11 bus back", busOe, 1);
    relReq = 1'b1;
    tick();
    chk("R11 grant during manual reset", relGnt, 1);
    relReq = 1'b0; manRst = 1'b0;
    repeat (3) tick();

    // R1: power-on reset mid access, effect without a clock edge
    reqAddr = 16'h1230; reqBurst = 1'b1; reqValid = 1'b1;
    hi = 0;
    while (!busCs && hi < 20) begin
      tick();
      hi++;
    end
    reqValid = 1'b0;
    #3 porRstN = 1'b0;
    #1;
    chk("R1 busCs cut at once", busCs, 0);
    chk("R1 drivers off at once", busOe, 0);
    tick();
    porRstN = 1'b1;
    tick();
    chk("R1 no done after power-on reset", reqDone, 0);
    waitRises(2);
    chk("R1 interval back to default", lastRise - prevRise, REF_DEF + 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule